// File: doc/BRIEF.md
# BCD Time-of-Day Clock Counter

This block keeps the time of day in four packed BCD registers: tenths of a second, seconds, minutes and hours, with an AM/PM flag in the hours register. A 50 Hz or 60 Hz line tick feeds a hidden prescaler. The prescaler divides the tick by 5 or 6 to make one pulse per tenth of a second, and that pulse drives the digit chain. All carries ripple through tenths, seconds, minutes and hours in the cycle of the pulse. A run input starts and stops both the prescaler and the counters.

Each digit is a plain binary counter with a decimal carry. A digit holding its last decimal value returns to zero and carries. A digit holding a value that was written and is out of range keeps counting in binary, wraps at its binary limit and does not carry. Software loads a register with a one-cycle write strobe and reads any register through a combinational read select.

Register select codes, used by both `wr_addr` and `rd_sel`: 0 = tenths, 1 = seconds, 2 = minutes, 3 = hours.

Top module: `tod_bcd_clock`

## Requirements
- R1: After reset the registers read tenths 0x00, seconds 0x00, minutes 0x00 and hours 0x81 (flag set, hour 01).
- R2: With `sel_50hz` = 0, one tenth-second pulse occurs every 6 line ticks. With `sel_50hz` = 1, one occurs every 5 line ticks. Ticks count only while `run` is high, and while `run` is low line ticks change nothing.
- R3: A write to tenths while `run` is low clears the prescaler count. A write to tenths while `run` is high leaves the prescaler count as it was.
- R4: Tenths occupies bits 3:0, and bits 7:4 always read 0. On a tenth pulse, 9 goes to 0 with a carry into seconds. 0xF goes to 0 with no carry. Any other value goes up by 1.
- R5: Seconds and minutes keep a 3-bit tens digit in bits 6:4 and a 4-bit units digit in bits 3:0, and bit 7 reads 0. The units digit goes from 9 to 0 with a carry into the tens digit, and from 0xF to 0 with no carry. The tens digit goes from 5 to 0 with a carry to the next register, and from 7 to 0 with no carry.
- R6: Hours (bit 7 flag, bit 4 tens digit, bits 3:0 units digit) count 01, 02 … 09, 10, 11, 12, 01. The step from 11 to 12 inverts the flag, and the step from 12 to 01 keeps it.
- R7: The hours units digit counts in binary past 9 when the tens digit is 1: 0x19 goes to 0x1A. From 0xF it goes to 0 and keeps both the tens digit and the flag. Bits 6:5 always read 0.
- R8: A write to hours whose bit 4 is 1 and whose bits 3:0 are 2 stores the flag inverted from bit 7 of the written data. Any other write stores the flag as written.
- R9: One tenth pulse from x:59:59.9 clears tenths, seconds and minutes and advances hours, all in the same cycle.
- R10: A write in the cycle of a tenth pulse replaces only the addressed register's next value. The other registers still advance and still carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per line period (50 or 60 Hz) |
| sel_50hz | input | 1 | 1: divide the line tick by 5, 0: divide it by 6 |
| run | input | 1 | High lets the prescaler and the counters advance |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register written (0 tenths, 1 seconds, 2 minutes, 3 hours) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register read (same codes as wr_addr) |
| rd_data | output | 8 | Contents of the selected register |

## Verification
The hardest situations to reach are the hidden prescaler states and an invalid digit meeting a carry. Neither can be seen or loaded from the ports. The bench puts the prescaler into a known partial count by giving a counted number of line ticks, and then stops the clock or leaves it running before writing tenths. The number of further ticks needed for the next pulse shows whether the clear took effect. For every value that seconds, minutes and hours can hold, the bench writes that value together with 9 in the lower registers, so that a single pulse drives a carry into the digit under test. It also lines up one write with the exact cycle of a pulse, to check that the write takes priority.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic [1:0] {
        REG_TENTHS = 2'd0,
        REG_SEC    = 2'd1,
        REG_MIN    = 2'd2,
        REG_HOUR   = 2'd3
    } tod_reg_e;

    typedef struct packed {
        logic       pm;
        logic       ten;
        logic [3:0] units;
    } hours_t;

    localparam hours_t HOURS_RESET = '{pm: 1'b1, ten: 1'b0, units: 4'd1};
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int DIV_50 = 5,
    parameter int DIV_60 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic line_tick,
    input  logic sel_50hz,
    input  logic clear,
    output logic tenth_pulse
);
    localparam int MAXDIV = (DIV_50 > DIV_60) ? DIV_50 : DIV_60;
    localparam int CNT_W  = $clog2(MAXDIV);
    localparam logic [CNT_W-1:0] LAST_50 = CNT_W'(DIV_50 - 1);
    localparam logic [CNT_W-1:0] LAST_60 = CNT_W'(DIV_60 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t             st_q, st_d;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d        = st_q;
        tenth_pulse = 1'b0;
        last        = sel_50hz ? LAST_50 : LAST_60;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run && line_tick) begin
            if (st_q.cnt >= last) begin
                st_d.cnt    = '0;
                tenth_pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a stopped clock leaves the hidden count alone
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(st_q.cnt));
    // R3: a clear request empties the count
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.cnt == '0));
    // R2: every pulse restarts the division
    a_r2_pulse_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        tenth_pulse |=> (st_q.cnt == '0));
endmodule

// File: rtl/tod_bcd_pair.sv
module tod_bcd_pair #(
    parameter int LO_W    = 4,
    parameter int HI_W    = 3,
    parameter int LO_LAST = 9,
    parameter int HI_LAST = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            wr,
    input  logic [HI_W-1:0] wr_hi,
    input  logic [LO_W-1:0] wr_lo,
    output logic [HI_W-1:0] hi_q,
    output logic [LO_W-1:0] lo_q,
    output logic            carry
);
    localparam logic [LO_W-1:0] LO_END = LO_W'(LO_LAST);
    localparam logic [HI_W-1:0] HI_END = HI_W'(HI_LAST);

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } pair_t;

    pair_t st_q, st_d;
    logic  lo_carry;

    always_comb begin
        st_d     = st_q;
        lo_carry = inc && (st_q.lo == LO_END);
        carry    = lo_carry && (st_q.hi == HI_END);
        if (inc) begin
            st_d.lo = lo_carry ? '0 : st_q.lo + 1'b1;
        end
        if (lo_carry) begin
            st_d.hi = carry ? '0 : st_q.hi + 1'b1;
        end
        if (wr) begin
            st_d.hi = wr_hi;
            st_d.lo = wr_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_q = st_q.hi;
    assign lo_q = st_q.lo;

    // R5: last decimal value of the pair returns to zero
    a_r5_decimal_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && lo_q == LO_END && hi_q == HI_END) |=> (lo_q == '0 && hi_q == '0));
    // R5: binary wrap of the units digit leaves the tens digit as it was
    a_r5_units_binary_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && lo_q == '1) |=> (lo_q == '0 && $stable(hi_q)));
    // R5: binary wrap of the tens digit sends no carry
    a_r5_tens_binary_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && hi_q == '1 && lo_q == LO_END) |-> !carry);
endmodule

// File: rtl/tod_hours.sv
module tod_hours
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       wr,
    input  logic       wr_pm,
    input  logic       wr_ten,
    input  logic [3:0] wr_units,
    output hours_t     hours_q
);
    hours_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (inc) begin
            if (st_q.ten && st_q.units == 4'd2) begin
                st_d.ten   = 1'b0;
                st_d.units = 4'd1;
            end else if (!st_q.ten && st_q.units == 4'd9) begin
                st_d.ten   = 1'b1;
                st_d.units = 4'd0;
            end else if (st_q.units == 4'hF) begin
                st_d.units = 4'd0;
            end else begin
                st_d.units = st_q.units + 4'd1;
                if (st_q.ten && st_q.units == 4'd1) st_d.pm = ~st_q.pm;
            end
        end
        if (wr) begin
            st_d.pm    = wr_pm ^ (wr_ten && wr_units == 4'd2);
            st_d.ten   = wr_ten;
            st_d.units = wr_units;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HOURS_RESET;
        else        st_q <= st_d;
    end

    assign hours_q = st_q;

    // R6: counting into twelve inverts the flag
    a_r6_noon_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && st_q.ten && st_q.units == 4'd1) |=> (st_q.pm != $past(st_q.pm)));
    // R6: twelve goes to one with the flag kept
    a_r6_twelve_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && st_q.ten && st_q.units == 4'd2)
        |=> (!st_q.ten && st_q.units == 4'd1 && $stable(st_q.pm)));
    // R7: binary wrap of the units keeps tens and flag
    a_r7_units_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && st_q.units == 4'hF)
        |=> (st_q.units == 4'd0 && $stable(st_q.ten) && $stable(st_q.pm)));
    // R8: writing twelve stores the inverted flag
    a_r8_write_twelve: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_ten && wr_units == 4'd2) |=> (st_q.pm == !$past(wr_pm)));
endmodule

// File: rtl/tod_bcd_clock.sv
module tod_bcd_clock
    import tod_pkg::*;
#(
    parameter int DIV_50 = 5,
    parameter int DIV_60 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_tick,
    input  logic       sel_50hz,
    input  logic       run,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data
);
    localparam int TEN_W = 4;
    localparam logic [TEN_W-1:0] TEN_LAST = TEN_W'(9);

    typedef struct packed {
        logic [TEN_W-1:0] tenths;
    } top_t;

    top_t       st_q, st_d;
    logic       pulse, t_carry, s_carry, m_carry;
    logic       wr_ten, wr_sec, wr_min, wr_hour, pre_clear;
    logic [2:0] sec_hi, min_hi;
    logic [3:0] sec_lo, min_lo;
    hours_t     hours;

    always_comb begin
        wr_ten    = wr_en && (wr_addr == REG_TENTHS);
        wr_sec    = wr_en && (wr_addr == REG_SEC);
        wr_min    = wr_en && (wr_addr == REG_MIN);
        wr_hour   = wr_en && (wr_addr == REG_HOUR);
        pre_clear = wr_ten && !run;
    end

    tod_prescaler #(.DIV_50(DIV_50), .DIV_60(DIV_60)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .line_tick(line_tick),
        .sel_50hz(sel_50hz), .clear(pre_clear), .tenth_pulse(pulse)
    );

    always_comb begin
        st_d    = st_q;
        t_carry = pulse && (st_q.tenths == TEN_LAST);
        if (pulse) st_d.tenths = t_carry ? '0 : st_q.tenths + 1'b1;
        if (wr_ten) st_d.tenths = wr_data[TEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tod_bcd_pair u_sec (
        .clk(clk), .rst_n(rst_n), .inc(t_carry), .wr(wr_sec),
        .wr_hi(wr_data[6:4]), .wr_lo(wr_data[3:0]),
        .hi_q(sec_hi), .lo_q(sec_lo), .carry(s_carry)
    );

    tod_bcd_pair u_min (
        .clk(clk), .rst_n(rst_n), .inc(s_carry), .wr(wr_min),
        .wr_hi(wr_data[6:4]), .wr_lo(wr_data[3:0]),
        .hi_q(min_hi), .lo_q(min_lo), .carry(m_carry)
    );

    tod_hours u_hours (
        .clk(clk), .rst_n(rst_n), .inc(m_carry), .wr(wr_hour),
        .wr_pm(wr_data[7]), .wr_ten(wr_data[4]), .wr_units(wr_data[3:0]),
        .hours_q(hours)
    );

    always_comb begin
        case (rd_sel)
            REG_TENTHS: rd_data = {4'h0, st_q.tenths};
            REG_SEC:    rd_data = {1'b0, sec_hi, sec_lo};
            REG_MIN:    rd_data = {1'b0, min_hi, min_lo};
            default:    rd_data = {hours.pm, 2'b00, hours.ten, hours.units};
        endcase
    end

    // R4: nine in tenths goes to zero on a pulse
    a_r4_tenths_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !wr_ten && st_q.tenths == TEN_LAST) |=> (st_q.tenths == '0));
    // R4: binary wrap of tenths sends nothing into seconds
    a_r4_no_carry_from_f: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tenths == '1) |-> !t_carry);
    // R9: a carry reaches hours only through a minutes carry
    a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
        m_carry |-> (s_carry && t_carry && pulse));
endmodule

// File: tb/tod_bcd_clock_test.sv
`timescale 1ns/1ps
module tod_bcd_clock_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic       sel_50hz = 1'b0;
    logic       run = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    tod_bcd_clock uut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .sel_50hz(sel_50hz),
        .run(run), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_sel = a;
        #1;
        v = rd_data;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_tick = 1'b1;
        end
        @(negedge clk);
        line_tick = 1'b0;
    endtask

    function automatic logic [7:0] pair_next(input logic [7:0] v, output logic cy);
        int lo, hi, lo_n, hi_n;
        lo = v & 15; hi = (v >> 4) & 7;
        lo_n = (lo == 9) ? 0 : (lo + 1) % 16;
        hi_n = hi;
        if (lo == 9) hi_n = (hi == 5) ? 0 : (hi + 1) % 8;
        cy = (lo == 9) && (hi == 5);
        return 8'((hi_n << 4) | lo_n);
    endfunction

    function automatic logic [7:0] hour_next(input logic [7:0] v);
        int p, t, u;
        p = v[7]; t = v[4]; u = v[3:0];
        if (t == 1 && u == 2) begin t = 0; u = 1; end
        else if (t == 0 && u == 9) begin t = 1; u = 0; end
        else if (u == 15) u = 0;
        else begin
            if (t == 1 && u == 1) p = 1 - p;
            u = u + 1;
        end
        return 8'((p << 7) | (t << 4) | u);
    endfunction

    initial begin
        logic [7:0] v, stored, exp;
        logic cy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents
        expect_reg("R1 tenths", 2'd0, 8'h00);
        expect_reg("R1 seconds", 2'd1, 8'h00);
        expect_reg("R1 minutes", 2'd2, 8'h00);
        expect_reg("R1 hours", 2'd3, 8'h81);

        // R2 divide by 6, then by 5, then stopped
        run = 1'b1;
        ticks(5);
        expect_reg("R2 div6 five ticks", 2'd0, 8'h00);
        ticks(1);
        expect_reg("R2 div6 sixth tick", 2'd0, 8'h01);
        sel_50hz = 1'b1;
        ticks(4);
        expect_reg("R2 div5 four ticks", 2'd0, 8'h01);
        ticks(1);
        expect_reg("R2 div5 fifth tick", 2'd0, 8'h02);
        run = 1'b0;
        ticks(10);
        expect_reg("R2 stopped ticks ignored", 2'd0, 8'h02);

        // R3 clear while stopped, no clear while running
        run = 1'b1;
        ticks(3);
        run = 1'b0;
        do_write(2'd0, 8'h00);
        run = 1'b1;
        ticks(4);
        expect_reg("R3 cleared prescaler four ticks", 2'd0, 8'h00);
        ticks(1);
        expect_reg("R3 cleared prescaler fifth tick", 2'd0, 8'h01);
        ticks(3);
        do_write(2'd0, 8'h05);
        ticks(2);
        expect_reg("R3 running write keeps count", 2'd0, 8'h06);

        // R4 tenths sweep
        for (int t = 0; t < 16; t++) begin
            do_write(2'd0, 8'(8'hA0 | t));
            do_write(2'd1, 8'h00);
            ticks(5);
            expect_reg("R4 tenths next", 2'd0, 8'((t == 9) ? 0 : (t + 1) % 16));
            expect_reg("R4 carry into seconds", 2'd1, 8'((t == 9) ? 1 : 0));
        end

        // R5 seconds sweep over every stored value
        for (int s = 0; s < 128; s++) begin
            do_write(2'd0, 8'h09);
            do_write(2'd1, 8'(8'h80 | s));
            do_write(2'd2, 8'h00);
            ticks(5);
            exp = pair_next(8'(s), cy);
            expect_reg("R5 seconds next", 2'd1, exp);
            expect_reg("R5 seconds carry", 2'd2, cy ? 8'h01 : 8'h00);
        end

        // R5 and R9 minutes sweep with full ripple
        for (int m = 0; m < 128; m++) begin
            do_write(2'd0, 8'h09);
            do_write(2'd1, 8'h59);
            do_write(2'd2, 8'(m));
            do_write(2'd3, 8'h01);
            ticks(5);
            exp = pair_next(8'(m), cy);
            expect_reg("R5 minutes next", 2'd2, exp);
            expect_reg("R9 seconds cleared", 2'd1, 8'h00);
            expect_reg("R9 hours carry", 2'd3, cy ? 8'h02 : 8'h01);
        end

        // R6 R7 R8 R9 hours sweep
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 2; t++) begin
                for (int u = 0; u < 16; u++) begin
                    v = 8'((p << 7) | (t << 4) | u | 8'h60);
                    stored = 8'((((t == 1 && u == 2) ? 1 - p : p) << 7) | (t << 4) | u);
                    do_write(2'd3, v);
                    expect_reg("R8 hours write readback", 2'd3, stored);
                    do_write(2'd0, 8'h09);
                    do_write(2'd1, 8'h59);
                    do_write(2'd2, 8'h59);
                    ticks(5);
                    expect_reg("R6 R7 hours next", 2'd3, hour_next(stored));
                    expect_reg("R9 minutes cleared", 2'd2, 8'h00);
                    expect_reg("R9 tenths cleared", 2'd0, 8'h00);
                end
            end
        end

        // R10 write in the pulse cycle
        do_write(2'd0, 8'h03);
        do_write(2'd1, 8'h20);
        ticks(4);
        @(negedge clk);
        line_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h45;
        @(negedge clk);
        line_tick = 1'b0; wr_en = 1'b0;
        expect_reg("R10 written seconds win", 2'd1, 8'h45);
        expect_reg("R10 tenths still advance", 2'd0, 8'h04);
        do_write(2'd0, 8'h09);
        do_write(2'd1, 8'h10);
        ticks(4);
        @(negedge clk);
        line_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h07;
        @(negedge clk);
        line_tick = 1'b0; wr_en = 1'b0;
        expect_reg("R10 written tenths win", 2'd0, 8'h07);
        expect_reg("R10 carry still reaches seconds", 2'd1, 8'h11);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule